// File: doc/BRIEF.md
# Dual-Format MDIO Management Master

This block runs management register transactions toward an Ethernet PHY over an MDC clock pin and a bidirectional MDIO data pin. Software controls it through four 32-bit registers: a configuration register holding the MDC half-period, a preamble enable and a frame-format select; a command register whose write launches one frame; a transmit-data register; and a receive-data register. The transmit-data and receive-data registers also carry the status flags that software polls.

The frame-format bit selects between the short (Clause 22) and the extended (Clause 45) management frame. The same 2-bit command opcode is decoded differently in each format. In extended format the opcode also selects an address frame, which sends the transmit-data register as the 16-bit register address. The block shifts the whole frame out MSB first and changes MDIO only while MDC is low. For reads it releases the line for the turnaround and data bits and samples MDIO on each MDC rising edge.

Register map (index on `csr_addr`): 0 configuration, 1 command, 2 transmit data, 3 receive data.

Top module: `mdio_master`

## Requirements
- R1: Configuration register (index 0) holds the MDC half-period in bits [15:0], the preamble enable in bit 16 and the format select in bit 17 (1 = extended, 0 = short). It reads back what was written and resets to half-period 4, preamble on, short format.
- R2: While a frame runs, MDC spends max(half-period,1) system clocks high and the same number low, starting low. MDC stays low while idle.
- R3: A frame is, in order: 32 ones only when the preamble is enabled; start bits 01 (short) or 00 (extended); 2 opcode bits; 5 PHY address bits; 5 register/device address bits; 2 turnaround bits; 16 data bits. Every field goes MSB first, and MDIO changes only while MDC is low.
- R4: Short format: a command opcode with bit 0 set is a read and goes on the wire as 10. Any other opcode is a write and goes on the wire as 01.
- R5: Extended format: the opcode goes on the wire unchanged. 00 is an address frame, 01 a write, and 11 or 10 a read. An address frame carries transmit-data [15:0] as its data.
- R6: For write and address frames the master drives every bit. The turnaround is 10 and the data bits are transmit-data [15:0].
- R7: For read frames the output enable is low for the last 18 bits (turnaround and data). MDIO is sampled at each MDC rising edge, and the 16 data bits land MSB first in receive-data [15:0].
- R8: Writing the command register (index 1: register/device address [4:0], PHY address [9:5], opcode [11:10]) launches exactly one frame. Transmit-data bit 16 is set for write and address frames, and receive-data bit 16 is set for reads. Each is set from the cycle after the write until the frame completes, and the two are never set together.
- R9: Receive-data bit 17 (valid) clears when a read launches and sets when it completes. It is never set together with receive-data bit 16.
- R10: A command write while either pending bit is set is ignored: no second frame is sent.
- R11: While idle the output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_we | input | 1 | Register write strobe |
| csr_addr | input | 2 | Register index |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data (combinational on csr_addr) |
| mdio_i | input | 1 | Sampled MDIO pin value |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value driven by the master |
| mdio_oe | output | 1 | MDIO output enable |

## Verification
The assertions assume that software leaves the configuration register alone while a frame runs. They also assume that the PHY side changes the sampled MDIO value only while MDC is low. The bench writes the configuration only between frames. Its PHY model updates MDIO only on MDC falling edges. Random frames mix both formats, all four opcodes, preamble on and off and half-periods from 0 to 4. Directed cases cover the reset state, a zero half-period and a command written while a frame is pending.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    localparam int PRE_BITS  = 32;
    localparam int BODY_BITS = 32;
    localparam int DATA_BITS = 16;
    localparam int TA_BITS   = 2;
    localparam int SHIFT_W   = PRE_BITS + BODY_BITS;
    localparam int LEN_W     = $clog2(SHIFT_W + 1);
    localparam int REL_BITS  = TA_BITS + DATA_BITS;

    localparam logic [1:0] IDX_CFG = 2'd0;
    localparam logic [1:0] IDX_CMD = 2'd1;
    localparam logic [1:0] IDX_TXD = 2'd2;
    localparam logic [1:0] IDX_RXD = 2'd3;

    typedef struct packed {
        logic [SHIFT_W-1:0] bits;
        logic [LEN_W-1:0]   len;
        logic               rd;
    } frame_t;

    // Builds the serial image of one frame, left aligned.
    function automatic frame_t build_frame(
        input logic                 ext,
        input logic                 pre,
        input logic [1:0]           op,
        input logic [4:0]           phy,
        input logic [4:0]           regad,
        input logic [DATA_BITS-1:0] wd
    );
        frame_t               f;
        logic [1:0]           st;
        logic [1:0]           wop;
        logic [1:0]           ta;
        logic [DATA_BITS-1:0] dat;
        logic [BODY_BITS-1:0] body;
        st = ext ? 2'b00 : 2'b01;
        if (ext) begin
            wop  = op;
            f.rd = op[1];
        end else begin
            f.rd = op[0];
            wop  = op[0] ? 2'b10 : 2'b01;
        end
        ta   = f.rd ? 2'b11 : 2'b10;
        dat  = f.rd ? '1 : wd;
        body = {st, wop, phy, regad, ta, dat};
        if (pre) begin
            f.bits = {{PRE_BITS{1'b1}}, body};
            f.len  = LEN_W'(SHIFT_W);
        end else begin
            f.bits = {body, {PRE_BITS{1'b0}}};
            f.len  = LEN_W'(BODY_BITS);
        end
        return f;
    endfunction
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [DIV_W-1:0] half_i,
    output logic             mdc_o,
    output logic             rise_o,
    output logic             fall_o
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             mdc;
    } cg_t;

    cg_t              d, q;
    logic [DIV_W-1:0] lim;
    logic             tick;

    always_comb begin
        d    = q;
        lim  = (half_i == '0) ? DIV_W'(1) : half_i;
        tick = run_i && (q.cnt == lim - DIV_W'(1));
        if (!run_i) begin
            d.cnt = '0;
            d.mdc = 1'b0;
        end else if (tick) begin
            d.cnt = '0;
            d.mdc = ~q.mdc;
        end else begin
            d.cnt = q.cnt + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mdc_o  = q.mdc;
    assign rise_o = tick && !q.mdc;
    assign fall_o = tick && q.mdc;

    // R2
    mdc_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |-> !q.mdc);
    // R2
    mdc_rise_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.mdc) |-> $past(run_i));
endmodule

// File: rtl/mdio_shifter.sv
module mdio_shifter
    import mdio_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  frame_t               frame_i,
    input  logic                 rise_i,
    input  logic                 fall_i,
    input  logic                 mdio_i,
    output logic                 run_o,
    output logic                 mdio_o,
    output logic                 mdio_oe_o,
    output logic                 done_o,
    output logic [DATA_BITS-1:0] rx_o
);
    typedef struct packed {
        logic                 run;
        logic [SHIFT_W-1:0]   sh;
        logic [LEN_W-1:0]     left;
        logic                 rd;
        logic [DATA_BITS-1:0] rx;
    } sh_t;

    sh_t  d, q;
    logic done;

    always_comb begin
        d    = q;
        done = 1'b0;
        if (!q.run) begin
            if (start_i) begin
                d.run  = 1'b1;
                d.sh   = frame_i.bits;
                d.left = frame_i.len;
                d.rd   = frame_i.rd;
            end
        end else begin
            if (rise_i && q.rd && (q.left <= LEN_W'(DATA_BITS)))
                d.rx = {q.rx[DATA_BITS-2:0], mdio_i};
            if (fall_i) begin
                if (q.left == LEN_W'(1)) begin
                    d.run = 1'b0;
                    done  = 1'b1;
                end else begin
                    d.left = q.left - LEN_W'(1);
                    d.sh   = {q.sh[SHIFT_W-2:0], 1'b0};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign run_o     = q.run;
    assign mdio_o    = q.run ? q.sh[SHIFT_W-1] : 1'b1;
    assign mdio_oe_o = q.run && !(q.rd && (q.left <= LEN_W'(REL_BITS)));
    assign done_o    = done;
    assign rx_o      = q.rx;

    // R8
    left_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.run |-> (q.left != '0));
    // R8
    done_ends_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !q.run);
    // R11
    idle_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !q.run |-> !mdio_oe_o);
endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int DIV_W    = 16,
    parameter int DEF_HALF = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        csr_we,
    input  logic [1:0]  csr_addr,
    input  logic [31:0] csr_wdata,
    output logic [31:0] csr_rdata,
    input  logic        mdio_i,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe
);
    localparam int PRE_POS = 16;
    localparam int EXT_POS = 17;

    typedef struct packed {
        logic [DIV_W-1:0]     half;
        logic                 pre;
        logic                 ext;
        logic [DATA_BITS-1:0] txd;
        logic                 tx_pend;
        logic [DATA_BITS-1:0] rxd;
        logic                 rx_pend;
        logic                 rx_valid;
    } regs_t;

    regs_t                d, q;
    frame_t               frm;
    logic                 busy, cmd_hit, launch;
    logic                 run, rise, fall, done;
    logic [DATA_BITS-1:0] rx_word;
    logic                 unused_wdata_hi;

    assign unused_wdata_hi = ^csr_wdata[31:18];

    always_comb begin
        d       = q;
        busy    = q.tx_pend || q.rx_pend;
        cmd_hit = csr_we && (csr_addr == IDX_CMD);
        launch  = cmd_hit && !busy;
        frm     = build_frame(q.ext, q.pre, csr_wdata[11:10], csr_wdata[9:5],
                              csr_wdata[4:0], q.txd);
        if (csr_we && csr_addr == IDX_CFG) begin
            d.half = csr_wdata[DIV_W-1:0];
            d.pre  = csr_wdata[PRE_POS];
            d.ext  = csr_wdata[EXT_POS];
        end
        if (csr_we && csr_addr == IDX_TXD)
            d.txd = csr_wdata[DATA_BITS-1:0];
        if (done) begin
            if (q.rx_pend) begin
                d.rxd      = rx_word;
                d.rx_valid = 1'b1;
            end
            d.rx_pend = 1'b0;
            d.tx_pend = 1'b0;
        end
        if (launch) begin
            if (frm.rd) begin
                d.rx_pend  = 1'b1;
                d.rx_valid = 1'b0;
            end else begin
                d.tx_pend = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.half <= DIV_W'(DEF_HALF);
            q.pre  <= 1'b1;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        csr_rdata = '0;
        unique case (csr_addr)
            IDX_CFG: begin
                csr_rdata[DIV_W-1:0] = q.half;
                csr_rdata[PRE_POS]   = q.pre;
                csr_rdata[EXT_POS]   = q.ext;
            end
            IDX_CMD: csr_rdata = '0;
            IDX_TXD: csr_rdata = {15'd0, q.tx_pend, q.txd};
            IDX_RXD: csr_rdata = {14'd0, q.rx_valid, q.rx_pend, q.rxd};
            default: csr_rdata = '0;
        endcase
    end

    mdio_clkgen #(.DIV_W(DIV_W)) u_clkgen (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run),
        .half_i (q.half),
        .mdc_o  (mdc),
        .rise_o (rise),
        .fall_o (fall)
    );

    mdio_shifter u_shifter (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (launch),
        .frame_i   (frm),
        .rise_i    (rise),
        .fall_i    (fall),
        .mdio_i    (mdio_i),
        .run_o     (run),
        .mdio_o    (mdio_o),
        .mdio_oe_o (mdio_oe),
        .done_o    (done),
        .rx_o      (rx_word)
    );

    // R3
    data_stable_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc && $past(mdc)) |-> $stable(mdio_o));
    // R8
    pend_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(q.tx_pend && q.rx_pend));
    // R8
    pend_clear_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(q.tx_pend) || $fell(q.rx_pend)) |-> $past(done));
    // R9
    valid_vs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(q.rx_pend && q.rx_valid));
    // R10
    busy_cmd_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_hit && busy && !done) |=> ($stable(q.tx_pend) && $stable(q.rx_pend)));
endmodule

// File: tb/mdio_master_bench.sv
module mdio_master_bench;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csr_we = 1'b0;
    logic [1:0]  csr_addr = 2'd0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;
    logic        mdio_i = 1'b1;
    logic        mdc, mdio_o, mdio_oe;

    int n_chk = 0;
    int n_fail = 0;
    bit done_flag = 1'b0;

    logic       cap_b [0:63];
    logic       cap_oe[0:63];
    int         k = 0;
    int         exp_len_tb = 32;
    logic [15:0] phy_data = '0;
    longint     t_rise[0:1];

    mdio_master u_mdio_master (
        .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_addr(csr_addr),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .mdio_i(mdio_i),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
    );

    always #(CLK_P/2) clk = ~clk;

    // PHY model: records each bit at MDC rise, drives read data after MDC fall
    always @(posedge mdc) begin
        if (k < 64) begin
            cap_b[k]  = mdio_o;
            cap_oe[k] = mdio_oe;
        end
        if (k < 2) t_rise[k] = $time;
        k = k + 1;
    end
    always @(negedge mdc) begin
        if (k >= exp_len_tb - 16 && k < exp_len_tb)
            mdio_i = phy_data[15 - (k - (exp_len_tb - 16))];
        else
            mdio_i = 1'b1;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic csr_wr(input logic [1:0] a, input logic [31:0] v);
        @(negedge clk);
        csr_we = 1'b1; csr_addr = a; csr_wdata = v;
        @(negedge clk);
        csr_we = 1'b0;
    endtask

    task automatic csr_rd(input logic [1:0] a, output logic [31:0] v);
        csr_addr = a;
        #1 v = csr_rdata;
    endtask

    // Expected serial image from the requirements (R3..R6)
    function automatic void exp_frame(input bit ext, input bit pre, input logic [1:0] op,
        input logic [4:0] phy, input logic [4:0] ra, input logic [15:0] wd,
        output logic [63:0] img, output int len, output bit rd);
        logic [1:0] wop;
        logic [31:0] b;
        rd  = ext ? op[1] : op[0];
        wop = ext ? op : (op[0] ? 2'b10 : 2'b01);
        b   = {(ext ? 2'b00 : 2'b01), wop, phy, ra, 2'b10, wd};
        if (pre) begin img = {32'hFFFF_FFFF, b}; len = 64; end
        else     begin img = {b, 32'h0};         len = 32; end
    endfunction

    task automatic run_frame(input bit ext, input bit pre, input int half,
        input logic [1:0] op, input logic [4:0] phy, input logic [4:0] ra,
        input logic [15:0] wd, input logic [15:0] pd, input bit extra);
        logic [63:0] img;
        int len, mism_b, mism_oe, guard, eh;
        bit rd, idle;
        logic [31:0] v;
        exp_frame(ext, pre, op, phy, ra, wd, img, len, rd);
        eh = (half == 0) ? 1 : half;
        csr_wr(2'd0, {14'd0, ext, pre, 16'(half)});
        csr_wr(2'd2, {16'd0, wd});
        exp_len_tb = len; phy_data = pd; k = 0; mdio_i = 1'b1;
        csr_wr(2'd1, {20'd0, op, phy, ra});
        csr_rd(2'd2, v);
        chk(v[16] == !rd, "R8", "tx pending after launch", v[16], !rd);
        csr_rd(2'd3, v);
        chk(v[16] == rd, "R8", "rx pending after launch", v[16], rd);
        if (rd) chk(v[17] == 1'b0, "R9", "valid cleared at read launch", v[17], 0);
        if (extra) csr_wr(2'd1, {20'd0, ~op, ~phy, ~ra});
        guard = 0; idle = 1'b0;
        while (!idle && guard < 5000) begin
            @(negedge clk);
            csr_rd(2'd2, v); idle = !v[16];
            csr_rd(2'd3, v); idle = idle && !v[16];
            guard++;
        end
        chk(idle, "R8", "frame completes", guard, 5000);
        repeat (4 * eh + 4) @(negedge clk);
        chk(k == len, extra ? "R10" : "R8", "MDC rising edges per command", k, len);
        mism_b = 0; mism_oe = 0;
        for (int i = 0; i < 64 && i < len; i++) begin
            bit eoe;
            eoe = !(rd && i >= len - 18);
            if (cap_oe[i] !== eoe) mism_oe++;
            if (eoe && cap_b[i] !== img[63 - i]) mism_b++;
        end
        chk(mism_b == 0, ext ? "R5" : "R4", "driven frame bits (R3 order)", mism_b, 0);
        chk(mism_oe == 0, rd ? "R7" : "R6", "output enable pattern", mism_oe, 0);
        chk((t_rise[1] - t_rise[0]) == 2 * eh * CLK_P, "R2", "MDC period",
            t_rise[1] - t_rise[0], 2 * eh * CLK_P);
        chk(!mdio_oe && !mdc, "R11", "idle: oe and MDC low", {mdio_oe, mdc}, 0);
        if (rd) begin
            csr_rd(2'd3, v);
            chk(v[15:0] == pd, "R7", "read data", v[15:0], pd);
            chk(v[17] == 1'b1, "R9", "valid after read", v[17], 1);
        end
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done_flag) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] v;
        int s;
        s = $urandom(32'h5EED);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        csr_rd(2'd0, v);
        chk(v == 32'h0001_0004, "R1", "config reset value", v, 32'h0001_0004);
        csr_rd(2'd3, v);
        chk(v == 32'h0, "R9", "receive register reset", v, 0);
        chk(!mdc && !mdio_oe, "R11", "reset idle pins", {mdc, mdio_oe}, 0);
        csr_wr(2'd0, 32'h0002_0007);
        csr_rd(2'd0, v);
        chk(v == 32'h0002_0007, "R1", "config readback", v, 32'h0002_0007);

        // directed corners
        run_frame(1'b0, 1'b1, 2, 2'd0, 5'h15, 5'h0A, 16'hA5C3, 16'h0, 1'b0);
        run_frame(1'b0, 1'b0, 1, 2'd1, 5'h1F, 5'h01, 16'h0, 16'hBEEF, 1'b0);
        run_frame(1'b1, 1'b1, 3, 2'd0, 5'h03, 5'h1E, 16'h8001, 16'h0, 1'b0);
        run_frame(1'b1, 1'b0, 0, 2'd3, 5'h10, 5'h07, 16'h0, 16'h1234, 1'b0);
        run_frame(1'b1, 1'b0, 2, 2'd1, 5'h0C, 5'h05, 16'h7E81, 16'h0, 1'b1);
        run_frame(1'b0, 1'b0, 2, 2'd1, 5'h02, 5'h11, 16'h0, 16'hC0DE, 1'b1);

        for (int t = 0; t < 24; t++) begin
            run_frame(1'($urandom), 1'($urandom), int'($urandom % 5), 2'($urandom),
                      5'($urandom), 5'($urandom), 16'($urandom), 16'($urandom), 1'b0);
        end

        done_flag = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule